// File: doc/BRIEF.md
# Buffer-Ready Interrupt Status and Boundary-Stopping DMA Address Walker

This block sits beside a flash controller's data buffer. It holds three interrupt registers: a status register, a status-enable register and a signal-enable register. It derives the two buffer-ready flags from the buffer's fill level measured against the packet size. It also runs the byte address counter of the buffer's DMA engine. Event pulses from the rest of the controller set status bits only where the status-enable register allows them. Software clears those bits by writing ones. The interrupt line is high whenever a status bit is set and the same signal-enable bit is also set.

The DMA address counter is 64 bits wide and advances by one for each accepted byte-transfer strobe. It accepts strobes only when the command's DMA mode field selects the buffer-driven mode, when it is not halted, and when the buffer can supply or accept a byte in the current direction. A programmable power-of-two boundary can halt the walk. When the low address bits are all ones at a transfer, the walker enters the halted state, raises the DMA status event and still advances the address. Only a write of the low address word releases it.

The walker is a three-state machine:
- IDLE: the mode field is not the buffer-driven value.
- ACTIVE: transfers may be accepted.
- HALTED: a boundary was crossed.

Its transitions are:
- IDLE to ACTIVE when the mode field equals 2.
- ACTIVE to IDLE when the mode field changes away from 2.
- ACTIVE to HALTED on a boundary hit.
- HALTED to ACTIVE or IDLE, chosen by the mode field, on a low-word write.

Top module: `bufdma_irq_ctrl`

## Requirements
- R1: The status read value carries the following bits:
  - bit 0: buffer write ready.
  - bit 1: buffer read ready.
  - bit 2: transfer complete.
  - bit 3: multi-bit error.
  - bit 4: error.
  - bit 6: DMA boundary.
  - bit 7: bus error.
  
  Bit 5 and bits 31:8 always read 0. The same bit positions apply to the status-enable and signal-enable registers. Register writes use `wr_sel` with these encodings:
  - 0: status-enable.
  - 1: signal-enable.
  - 2: status (write-one-to-clear).
  - 3: DMA address low word.
  - 4: DMA address high word.
  - 5: boundary.
  
  Writes with any other `wr_sel` value are ignored.
- R2: An event pulse sets its status bit at the next clock edge only if the matching status-enable bit is 1. Writing 1 to an event bit of the status register clears it. An event in the same cycle as a clear leaves the bit set.
- R3: `irq` is 1 exactly when, for some bit, both the status bit and the signal-enable bit are 1.
- R4: Status bit 0 is recomputed every cycle. It is 1 when (`buf_cap` - `buf_count`) is at least the effective packet size and status-enable bit 0 is 1.
- R5: Status bit 1 is recomputed every cycle. It is 1 when `buf_count` is at least the effective packet size, the effective size is nonzero, and status-enable bit 1 is 1.
- R6: The effective packet size is `pkt_size`/2 (rounded down) when `short_op` is 1 and `ddr_mode` is nonzero. Otherwise it is `pkt_size`.
- R7: `dma_go` is 1 only when all of the following hold:
  - `dma_mode` has equalled 2 at the previous clock edge and still equals 2, so the walker is ACTIVE.
  - The walker is not HALTED.
  - The buffer can take part in the transfer: `buf_count` is nonzero when `dir_read` is 1, and `buf_count` is below `buf_cap` when `dir_read` is 0.
- R8: Each `xfer_strobe` while `dma_go` is 1 adds 1 to `dma_addr`. Without an accepted strobe or an address write, `dma_addr` holds its value.
- R9: The boundary register uses bit 3 as the enable and bits 2:0 as k. When the enable is set and the low (k+12) bits of `dma_addr` are all ones at an accepted strobe, three things happen: `dma_blocked` becomes 1, status bit 6 is set (if enabled), and the address is still incremented.
- R10: Writing the low word loads `dma_addr` with {held high word, new low word} and clears `dma_blocked`. Writing the high word loads {new high word, held low word} and leaves `dma_blocked` unchanged. An address write takes priority over a strobe in the same cycle.
- R11: After reset the following are all 0: the status, both enable registers, `irq`, `dma_addr`, `dma_blocked` and `dma_go`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| wr_en | input | 1 | Register write strobe |
| wr_sel | input | 3 | Register select for the write |
| wr_data | input | 32 | Register write data |
| evt_xfer_done | input | 1 | Transfer-complete event pulse |
| evt_multi_err | input | 1 | Multi-bit error event pulse |
| evt_err | input | 1 | Error event pulse |
| evt_bus_err | input | 1 | Bus error event pulse |
| buf_count | input | 16 | Bytes held in the data buffer |
| buf_cap | input | 16 | Buffer capacity in bytes |
| pkt_size | input | 11 | Programmed packet size |
| short_op | input | 1 | Current operation is a short register-style transfer |
| ddr_mode | input | 2 | Data interface mode field |
| dma_mode | input | 2 | DMA mode field of the command |
| dir_read | input | 1 | 1: buffer drains to memory, 0: memory fills buffer |
| xfer_strobe | input | 1 | One-byte transfer attempt |
| irq | output | 1 | Interrupt line |
| status_rd | output | 32 | Status register read value |
| dma_addr | output | 64 | Current DMA byte address |
| dma_blocked | output | 1 | Walker halted at a boundary |
| dma_go | output | 1 | A strobe this cycle would be accepted |

## Verification
The hardest situation to reach is the halted state followed by the recovery writes. The address must sit exactly one byte below a 2^(k+12) boundary while the walker is ACTIVE and the buffer is non-empty. The stimulus loads the address through the high and low word writes to land a few bytes short of the boundary, then issues single strobes across it. It then checks three things in turn: that further strobes are refused, that a high-word write moves the address without releasing the halt, and that only a low-word write releases it. A second pass with a larger exponent confirms that the first boundary is no longer a stop point.

// File: rtl/bdi_pkg.sv
package bdi_pkg;

    // register select codes
    localparam logic [2:0] SEL_STAT_EN = 3'd0;
    localparam logic [2:0] SEL_SIG_EN  = 3'd1;
    localparam logic [2:0] SEL_STATUS  = 3'd2;
    localparam logic [2:0] SEL_ADDR_LO = 3'd3;
    localparam logic [2:0] SEL_ADDR_HI = 3'd4;
    localparam logic [2:0] SEL_BOUND   = 3'd5;

    // status bit positions
    localparam int B_WR_RDY  = 0;
    localparam int B_RD_RDY  = 1;
    localparam int B_XFER    = 2;
    localparam int B_MULTI   = 3;
    localparam int B_ERR     = 4;
    localparam int B_DMA     = 6;
    localparam int B_BUS     = 7;

    localparam logic [7:0] STAT_MASK  = 8'hDF;
    localparam logic [7:0] EVENT_MASK = 8'hDC;

    localparam logic [1:0] DMA_MODE_BUF = 2'd2;

    typedef enum logic [1:0] {
        DW_IDLE,
        DW_ACTIVE,
        DW_HALTED
    } dw_state_e;

endpackage

// File: rtl/bdi_ready_calc.sv
module bdi_ready_calc #(
    parameter int CNT_W = 16,
    parameter int PKT_W = 11
) (
    input  logic [CNT_W-1:0] buf_count,
    input  logic [CNT_W-1:0] buf_cap,
    input  logic [PKT_W-1:0] pkt_size,
    input  logic             short_op,
    input  logic [1:0]       ddr_mode,
    output logic             wr_rdy,
    output logic             rd_rdy
);
    localparam int CW = ((CNT_W > PKT_W) ? CNT_W : PKT_W) + 1;

    logic [PKT_W-1:0] eff_size;
    logic [CW-1:0]    eff_x;
    logic [CW-1:0]    cnt_x;
    logic [CW-1:0]    free_x;

    always_comb begin
        if (short_op && (ddr_mode != 2'd0))
            eff_size = pkt_size >> 1;
        else
            eff_size = pkt_size;
        eff_x = CW'(eff_size);
        cnt_x = CW'(buf_count);
        if (buf_count > buf_cap)
            free_x = '0;
        else
            free_x = CW'(buf_cap) - CW'(buf_count);
        wr_rdy = (free_x >= eff_x);
        rd_rdy = (cnt_x >= eff_x) && (eff_size != '0);
    end
endmodule

// File: rtl/bdi_irq_regs.sv
module bdi_irq_regs
    import bdi_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       wr_en,
    input  logic [2:0] wr_sel,
    input  logic [7:0] wr_byte,
    input  logic [7:0] events,
    input  logic       wr_rdy,
    input  logic       rd_rdy,
    output logic [7:0] status_q,
    output logic       irq
);
    logic [7:0] stat_en_q;
    logic [7:0] sig_en_q;
    logic [7:0] clr_mask;
    logic [7:0] set_mask;
    logic [7:0] stat_next;

    always_comb begin
        clr_mask = (wr_en && wr_sel == SEL_STATUS) ? (wr_byte & EVENT_MASK) : 8'h00;
        set_mask = events & stat_en_q & EVENT_MASK;
        stat_next = ((status_q & ~clr_mask) | set_mask) & EVENT_MASK;
        stat_next[B_WR_RDY] = wr_rdy & stat_en_q[B_WR_RDY];
        stat_next[B_RD_RDY] = rd_rdy & stat_en_q[B_RD_RDY];
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            stat_en_q <= '0;
            sig_en_q  <= '0;
            status_q  <= '0;
        end else begin
            status_q <= stat_next;
            if (wr_en && wr_sel == SEL_STAT_EN)
                stat_en_q <= wr_byte & STAT_MASK;
            if (wr_en && wr_sel == SEL_SIG_EN)
                sig_en_q <= wr_byte & STAT_MASK;
        end
    end

    assign irq = |(sig_en_q & status_q);
endmodule

// File: rtl/bdi_dma_walker.sv
module bdi_dma_walker
    import bdi_pkg::*;
#(
    parameter int CNT_W      = 16,
    parameter int REG_W      = 32,
    parameter int BASE_SHIFT = 12
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [1:0]         dma_mode,
    input  logic               dir_read,
    input  logic [CNT_W-1:0]   buf_count,
    input  logic [CNT_W-1:0]   buf_cap,
    input  logic               xfer_strobe,
    input  logic               wr_en,
    input  logic [2:0]         wr_sel,
    input  logic [REG_W-1:0]   wr_data,
    output logic [2*REG_W-1:0] dma_addr,
    output logic               blocked,
    output logic               go,
    output logic               hit
);
    localparam int ADDR_W = 2 * REG_W;

    dw_state_e        state_q, state_d;
    logic [REG_W-1:0] lo_q, hi_q;
    logic [3:0]       bound_q;
    logic [7:0]       span;
    logic [ADDR_W-1:0] span_mask;
    logic             buf_ok;
    logic             take;
    logic             wr_lo, wr_hi;

    assign wr_lo = wr_en && (wr_sel == SEL_ADDR_LO);
    assign wr_hi = wr_en && (wr_sel == SEL_ADDR_HI);

    // output process
    always_comb begin
        buf_ok    = dir_read ? (buf_count != '0) : (buf_count < buf_cap);
        go        = 1'b0;
        blocked   = 1'b0;
        unique case (state_q)
            DW_IDLE:   go = 1'b0;
            DW_ACTIVE: go = (dma_mode == DMA_MODE_BUF) && buf_ok;
            DW_HALTED: blocked = 1'b1;
            default:   go = 1'b0;
        endcase
        take      = go && xfer_strobe && !wr_lo && !wr_hi;
        span      = 8'(bound_q[2:0]) + 8'(BASE_SHIFT);
        span_mask = ~({ADDR_W{1'b1}} << span);
        hit       = take && bound_q[3] && ((dma_addr & span_mask) == span_mask);
    end

    // next-state logic
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            DW_IDLE:
                if (dma_mode == DMA_MODE_BUF) state_d = DW_ACTIVE;
            DW_ACTIVE:
                if (hit) state_d = DW_HALTED;
                else if (dma_mode != DMA_MODE_BUF) state_d = DW_IDLE;
            DW_HALTED:
                if (wr_lo)
                    state_d = (dma_mode == DMA_MODE_BUF) ? DW_ACTIVE : DW_IDLE;
            default: state_d = DW_IDLE;
        endcase
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= DW_IDLE;
        else        state_q <= state_d;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            lo_q     <= '0;
            hi_q     <= '0;
            bound_q  <= '0;
            dma_addr <= '0;
        end else begin
            if (wr_en && wr_sel == SEL_BOUND)
                bound_q <= wr_data[3:0];
            if (wr_lo) begin
                lo_q     <= wr_data;
                dma_addr <= {hi_q, wr_data};
            end else if (wr_hi) begin
                hi_q     <= wr_data;
                dma_addr <= {wr_data, lo_q};
            end else if (take) begin
                dma_addr <= dma_addr + 1'b1;
            end
        end
    end
endmodule

// File: rtl/bufdma_irq_ctrl.sv
module bufdma_irq_ctrl
    import bdi_pkg::*;
#(
    parameter int CNT_W      = 16,
    parameter int PKT_W      = 11,
    parameter int REG_W      = 32,
    parameter int BASE_SHIFT = 12
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               wr_en,
    input  logic [2:0]         wr_sel,
    input  logic [REG_W-1:0]   wr_data,
    input  logic               evt_xfer_done,
    input  logic               evt_multi_err,
    input  logic               evt_err,
    input  logic               evt_bus_err,
    input  logic [CNT_W-1:0]   buf_count,
    input  logic [CNT_W-1:0]   buf_cap,
    input  logic [PKT_W-1:0]   pkt_size,
    input  logic               short_op,
    input  logic [1:0]         ddr_mode,
    input  logic [1:0]         dma_mode,
    input  logic               dir_read,
    input  logic               xfer_strobe,
    output logic               irq,
    output logic [REG_W-1:0]   status_rd,
    output logic [2*REG_W-1:0] dma_addr,
    output logic               dma_blocked,
    output logic               dma_go
);
    logic       wr_rdy, rd_rdy;
    logic       dma_hit;
    logic [7:0] events;
    logic [7:0] status_q;

    always_comb begin
        events          = '0;
        events[B_XFER]  = evt_xfer_done;
        events[B_MULTI] = evt_multi_err;
        events[B_ERR]   = evt_err;
        events[B_DMA]   = dma_hit;
        events[B_BUS]   = evt_bus_err;
    end

    bdi_ready_calc #(.CNT_W(CNT_W), .PKT_W(PKT_W)) u_ready (
        .buf_count (buf_count),
        .buf_cap   (buf_cap),
        .pkt_size  (pkt_size),
        .short_op  (short_op),
        .ddr_mode  (ddr_mode),
        .wr_rdy    (wr_rdy),
        .rd_rdy    (rd_rdy)
    );

    bdi_irq_regs u_irq (
        .clk      (clk),
        .rst_n    (rst_n),
        .wr_en    (wr_en),
        .wr_sel   (wr_sel),
        .wr_byte  (wr_data[7:0]),
        .events   (events),
        .wr_rdy   (wr_rdy),
        .rd_rdy   (rd_rdy),
        .status_q (status_q),
        .irq      (irq)
    );

    bdi_dma_walker #(.CNT_W(CNT_W), .REG_W(REG_W), .BASE_SHIFT(BASE_SHIFT)) u_walk (
        .clk         (clk),
        .rst_n       (rst_n),
        .dma_mode    (dma_mode),
        .dir_read    (dir_read),
        .buf_count   (buf_count),
        .buf_cap     (buf_cap),
        .xfer_strobe (xfer_strobe),
        .wr_en       (wr_en),
        .wr_sel      (wr_sel),
        .wr_data     (wr_data),
        .dma_addr    (dma_addr),
        .blocked     (dma_blocked),
        .go          (dma_go),
        .hit         (dma_hit)
    );

    assign status_rd = {{(REG_W-8){1'b0}}, status_q};
endmodule

// File: rtl/bufdma_irq_chk.sv
module bufdma_irq_chk #(
    parameter int REG_W = 32
) (
    input logic               clk,
    input logic               rst_n,
    input logic               wr_en,
    input logic [2:0]         wr_sel,
    input logic [REG_W-1:0]   wr_data,
    input logic               evt_xfer_done,
    input logic               xfer_strobe,
    input logic               irq,
    input logic [REG_W-1:0]   status_rd,
    input logic [2*REG_W-1:0] dma_addr,
    input logic               dma_blocked,
    input logic               dma_go
);
    AST_RSVD_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        (status_rd[REG_W-1:8] == '0) && !status_rd[5]); // R1

    AST_W1C_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && wr_sel == 3'd2 && wr_data[2] && !evt_xfer_done) |=> !status_rd[2]); // R2

    AST_IRQ_NEEDS_STATUS: assert property (@(posedge clk) disable iff (!rst_n)
        irq |-> (status_rd[7:0] != 8'h00)); // R3

    AST_HALT_NO_GO: assert property (@(posedge clk) disable iff (!rst_n)
        dma_blocked |-> !dma_go); // R7

    AST_ADDR_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        (xfer_strobe && dma_go && !wr_en) |=> (dma_addr == $past(dma_addr) + 1'b1)); // R8

    AST_ADDR_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (!(xfer_strobe && dma_go) && !wr_en) |=> $stable(dma_addr)); // R8

    AST_HALT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (dma_blocked && !(wr_en && wr_sel == 3'd3)) |=> dma_blocked); // R10

    AST_LO_RELEASE: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && wr_sel == 3'd3) |=> !dma_blocked); // R10
endmodule

bind bufdma_irq_ctrl bufdma_irq_chk #(.REG_W(REG_W)) u_chk (
    .clk           (clk),
    .rst_n         (rst_n),
    .wr_en         (wr_en),
    .wr_sel        (wr_sel),
    .wr_data       (wr_data),
    .evt_xfer_done (evt_xfer_done),
    .xfer_strobe   (xfer_strobe),
    .irq           (irq),
    .status_rd     (status_rd),
    .dma_addr      (dma_addr),
    .dma_blocked   (dma_blocked),
    .dma_go        (dma_go)
);

// File: tb/bufdma_irq_ctrl_tb_top.sv
module bufdma_irq_ctrl_tb_top;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        wr_en = 1'b0;
    logic [2:0]  wr_sel = '0;
    logic [31:0] wr_data = '0;
    logic        evt_xfer_done = 1'b0, evt_multi_err = 1'b0, evt_err = 1'b0, evt_bus_err = 1'b0;
    logic [15:0] buf_count = '0, buf_cap = 16'd64;
    logic [10:0] pkt_size = 11'd16;
    logic        short_op = 1'b0;
    logic [1:0]  ddr_mode = '0, dma_mode = '0;
    logic        dir_read = 1'b1, xfer_strobe = 1'b0;
    logic        irq, dma_blocked, dma_go;
    logic [31:0] status_rd;
    logic [63:0] dma_addr;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always #10 clk = ~clk;

    bufdma_irq_ctrl dut_i (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_sel(wr_sel), .wr_data(wr_data),
        .evt_xfer_done(evt_xfer_done), .evt_multi_err(evt_multi_err), .evt_err(evt_err),
        .evt_bus_err(evt_bus_err), .buf_count(buf_count), .buf_cap(buf_cap),
        .pkt_size(pkt_size), .short_op(short_op), .ddr_mode(ddr_mode),
        .dma_mode(dma_mode), .dir_read(dir_read), .xfer_strobe(xfer_strobe),
        .irq(irq), .status_rd(status_rd), .dma_addr(dma_addr),
        .dma_blocked(dma_blocked), .dma_go(dma_go)
    );

    // count, cap, pkt, short_op, ddr, exp_wr, exp_rd
    localparam logic [47:0] VEC [10] = '{
        {16'd0,  16'd64, 11'd16, 1'b0, 2'd0, 1'b1, 1'b0},
        {16'd16, 16'd64, 11'd16, 1'b0, 2'd0, 1'b1, 1'b1},
        {16'd60, 16'd64, 11'd16, 1'b0, 2'd0, 1'b0, 1'b1},
        {16'd48, 16'd64, 11'd16, 1'b0, 2'd0, 1'b1, 1'b1},
        {16'd8,  16'd64, 11'd16, 1'b1, 2'd1, 1'b1, 1'b1},
        {16'd8,  16'd64, 11'd16, 1'b0, 2'd1, 1'b1, 1'b0},
        {16'd8,  16'd64, 11'd16, 1'b1, 2'd0, 1'b1, 1'b0},
        {16'd0,  16'd64, 11'd0,  1'b0, 2'd0, 1'b1, 1'b0},
        {16'd60, 16'd64, 11'd9,  1'b1, 2'd2, 1'b1, 1'b1},
        {16'd64, 16'd64, 11'd1,  1'b0, 2'd0, 1'b0, 1'b1}
    };

    task automatic step();
        @(posedge clk);
        @(negedge clk);
    endtask

    task automatic chk(string req, logic [63:0] act, logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic reg_wr(logic [2:0] sel, logic [31:0] data);
        wr_en = 1'b1; wr_sel = sel; wr_data = data;
        step();
        wr_en = 1'b0;
    endtask

    task automatic strobe();
        xfer_strobe = 1'b1;
        step();
        xfer_strobe = 1'b0;
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1'b1;
            $display("  Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        checks++; errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        finish_run();
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        step();
        // R11 reset state
        chk("R11 status", status_rd, 0);
        chk("R11 irq", irq, 0);
        chk("R11 addr", dma_addr, 0);
        chk("R11 blocked", dma_blocked, 0);
        chk("R11 go", dma_go, 0);

        // R4 R5 gating off: enables at 0, ready conditions true
        buf_count = 16'd16;
        step();
        chk("R4 R5 gated", status_rd[1:0], 2'b00);

        // R4 R5 R6 table
        reg_wr(3'd0, 32'h03);
        foreach (VEC[i]) begin
            {buf_count, buf_cap, pkt_size, short_op, ddr_mode} = VEC[i][47:2];
            step();
            chk($sformatf("R4 write ready vec %0d", i), status_rd[0], VEC[i][1]);
            chk($sformatf("R5 R6 read ready vec %0d", i), status_rd[1], VEC[i][0]);
        end

        // R1 ignored select, reserved bits
        reg_wr(3'd0, 32'hFFFF_FFFF);
        reg_wr(3'd7, 32'hFFFF_FFFF);
        chk("R1 reserved bits", {status_rd[31:8], status_rd[5]}, 0);
        chk("R1 ignored select", status_rd[7:2], 0);

        // R2 enable gating and w1c
        reg_wr(3'd0, 32'h04);
        evt_multi_err = 1'b1; step(); evt_multi_err = 1'b0;
        chk("R2 disabled event", status_rd[3], 0);
        evt_xfer_done = 1'b1; step(); evt_xfer_done = 1'b0;
        chk("R2 enabled event", status_rd[2], 1);
        chk("R3 no signal enable", irq, 0);
        reg_wr(3'd1, 32'h04);
        chk("R3 irq raised", irq, 1);
        evt_xfer_done = 1'b1;
        reg_wr(3'd2, 32'h04);
        evt_xfer_done = 1'b0;
        chk("R2 event beats clear", status_rd[2], 1);
        reg_wr(3'd2, 32'h04);
        chk("R2 w1c", status_rd[2], 0);
        chk("R3 irq dropped", irq, 0);

        // R7 R8 R9 DMA boundary walk
        reg_wr(3'd0, 32'h40);
        reg_wr(3'd1, 32'h40);
        buf_count = 16'd10; buf_cap = 16'd64; dir_read = 1'b1;
        reg_wr(3'd4, 32'h1);
        reg_wr(3'd3, 32'h0000_0FFD);
        reg_wr(3'd5, 32'h8);
        chk("R10 address load", dma_addr, 64'h1_0000_0FFD);
        chk("R7 idle no go", dma_go, 0);
        dma_mode = 2'd2;
        step();
        chk("R7 active go", dma_go, 1);
        strobe();
        chk("R8 step", dma_addr, 64'h1_0000_0FFE);
        strobe();
        chk("R8 step2", dma_addr, 64'h1_0000_0FFF);
        chk("R9 not yet halted", dma_blocked, 0);
        strobe();
        chk("R9 halted", dma_blocked, 1);
        chk("R9 address still advanced", dma_addr, 64'h1_0000_1000);
        chk("R9 dma status", status_rd[6], 1);
        chk("R9 irq", irq, 1);
        chk("R7 no go when halted", dma_go, 0);
        strobe();
        chk("R7 strobe refused", dma_addr, 64'h1_0000_1000);
        reg_wr(3'd4, 32'h2);
        chk("R10 high reload", dma_addr, 64'h2_0000_0FFD);
        chk("R10 high keeps halt", dma_blocked, 1);
        reg_wr(3'd3, 32'h0);
        chk("R10 low reload", dma_addr, 64'h2_0000_0000);
        chk("R10 low releases", dma_blocked, 0);
        step();
        chk("R7 go resumes", dma_go, 1);

        // R7 buffer conditions
        buf_count = 16'd0; step();
        chk("R7 read empty", dma_go, 0);
        dir_read = 1'b0; buf_count = 16'd64; step();
        chk("R7 write full", dma_go, 0);
        buf_count = 16'd63; step();
        chk("R7 write space", dma_go, 1);
        dma_mode = 2'd1; step();
        chk("R7 wrong mode", dma_go, 0);
        strobe();
        chk("R8 hold without go", dma_addr, 64'h2_0000_0000);
        dma_mode = 2'd2; step();

        // R9 boundary disabled
        reg_wr(3'd5, 32'h0);
        reg_wr(3'd3, 32'h0000_0FFF);
        strobe();
        chk("R9 disabled no halt", dma_blocked, 0);
        chk("R9 disabled step", dma_addr, 64'h2_0000_1000);

        // R9 larger exponent
        reg_wr(3'd5, 32'h9);
        reg_wr(3'd3, 32'h0000_0FFF);
        strobe();
        chk("R9 k1 passes 4K", dma_blocked, 0);
        reg_wr(3'd3, 32'h0000_1FFF);
        strobe();
        chk("R9 k1 halts 8K", dma_blocked, 1);
        chk("R9 k1 addr", dma_addr, 64'h2_0000_2000);

        finish_run();
    end
endmodule